// File: doc/BRIEF.md
# Write-Through Snooping Coherence Controller

This block keeps one small direct-mapped, write-through cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and a single state bit: Valid or Invalid. Processor reads that hit a Valid line are answered in the same cycle. Read misses fetch the word over the bus and install it. Every processor write, hit or miss, is sent to memory as a bus write. A write hit also refreshes the cached copy.

The controller also watches transactions placed on the bus by other caches. A write by another cache to an address held Valid here drops the local copy to Invalid. Snooped reads, and traffic tagged with this cache's own source number, leave the lines alone. The parameter `WRITE_ALLOC` sets the write-miss policy. When it is 0, a write miss only updates memory. When it is 1, a write miss also installs the written word as a Valid line.

The sequencer has three states. ST_IDLE accepts requests and serves read hits. ST_BUS_REQ holds the bus request until it is granted. ST_BUS_WAIT waits for the bus to signal completion. The transitions are:
- accept (ST_IDLE to ST_BUS_REQ) on any write or any read miss;
- grant (ST_BUS_REQ to ST_BUS_WAIT) when `bus_gnt` is seen;
- complete (ST_BUS_WAIT to ST_IDLE) when `bus_done` is seen, which releases the processor;
- hold (self loop) in each state otherwise.

Top module: `wtc_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any address issues a bus read; during reset `cpu_ready` and `bus_req` are low.
- R2: A read miss issues a bus read (`bus_we`=0) of the word address. The controller raises `cpu_ready` with `cpu_rdata` equal to `bus_rdata` in the cycle `bus_done` is high, and the line becomes Valid.
- R3: A read of a Valid line with a matching tag raises `cpu_ready` in the same cycle with the cached word and raises no `bus_req`.
- R4: Every processor write issues a bus write (`bus_we`=1) carrying the request's address and data. `cpu_ready` rises only in the cycle `bus_done` is high.
- R5: A write to a Valid line updates the cached word and leaves the line Valid, so a following read hits and returns the new word.
- R6: With `WRITE_ALLOC`=0, a write to an Invalid line leaves it Invalid, so a following read of that address misses.
- R7: With `WRITE_ALLOC`=1, a write to an Invalid line installs it as Valid with the written word, so a following read hits.
- R8: A snooped write (`snp_valid`=1, `snp_we`=1) from a source other than `MY_ID` invalidates the line only if that line is Valid and its tag matches. A matching line then misses on its next read. A snooped write to the same index with a different tag has no effect.
- R9: Snooped reads (`snp_we`=0), and snooped traffic whose `snp_src` equals `MY_ID`, leave line state unchanged.
- R10: If a foreign snooped write and a local request to the same address arrive in the same cycle, the invalidation is applied first. The local request is then handled as a miss.
- R11: `bus_req` stays high with stable `bus_addr`, `bus_we` and `bus_wdata` until `bus_gnt`. `cpu_ready` stays low from accept until completion.
- R12: A foreign snooped write to the pending address in the completion cycle prevents the line from being installed or refreshed. The processor still receives the bus data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | Request completes in this cycle |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_gnt | input | 1 | One-cycle grant of the pending request |
| bus_done | input | 1 | One-cycle completion of the granted transaction |
| bus_rdata | input | DW | Read data, valid with `bus_done` |
| snp_valid | input | 1 | Snooped transaction present |
| snp_we | input | 1 | Snooped transaction is a write |
| snp_src | input | ID_W | Source number of the snooped transaction |
| snp_addr | input | AW | Snooped word address |

## Verification
The assertions assume the following about the block's inputs:
- the processor holds its request and operands steady until `cpu_ready`;
- the bus raises `bus_gnt` and `bus_done` only for this cache's outstanding request, and only once each, in that order.

The bench meets these assumptions by construction. A single task drives each processor request and releases it only after the ready cycle. A bus responder model grants one request at a time and completes it two cycles later. Snoop events are driven only between requests, or in the first or completion cycle of a request, which is where the same-cycle rules apply. The bench compares every read result and every hit/miss outcome against a reference model of line state and memory.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BUS_REQ  = 2'd1,
        ST_BUS_WAIT = 2'd2
    } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 13,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_vld,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [DW-1:0]            rd_data,
    input  logic [$clog2(LINES)-1:0] snp_idx,
    output logic                     snp_vld,
    output logic [TAG_W-1:0]         snp_tag,
    input  logic                     inv_en,
    input  logic [$clog2(LINES)-1:0] inv_idx,
    input  logic                     fill_en,
    input  logic [$clog2(LINES)-1:0] fill_idx,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic [DW-1:0]            fill_data
);
    localparam int IDX_W = $clog2(LINES);

    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [DW-1:0]    dat_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b1;
                end else if (inv_en && inv_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
            dat_q[fill_idx] <= fill_data;
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = dat_q[rd_idx];
    assign snp_vld = vld_q[snp_idx];
    assign snp_tag = tag_q[snp_idx];

    // R2
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_idx)]);

    // R8
    inv_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(fill_en && fill_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/wtc_snoop.sv
module wtc_snoop #(
    parameter int AW    = 16,
    parameter int LINES = 8,
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snp_valid,
    input  logic                     snp_we,
    input  logic [ID_W-1:0]          snp_src,
    input  logic [AW-1:0]            snp_addr,
    input  logic                     line_vld,
    input  logic [AW-$clog2(LINES)-1:0] line_tag,
    output logic [$clog2(LINES)-1:0] line_idx,
    output logic                     inv_en,
    output logic                     foreign_wr
);
    localparam int IDX_W = $clog2(LINES);

    assign foreign_wr = snp_valid && snp_we && (snp_src != ID_W'(MY_ID));
    assign line_idx   = snp_addr[IDX_W-1:0];
    assign inv_en     = foreign_wr && line_vld && (line_tag == snp_addr[AW-1:IDX_W]);

    // R9
    own_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_src == ID_W'(MY_ID)) |-> !inv_en);

    // R9
    snp_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_we) |-> !inv_en);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int LINES       = 8,
    parameter bit WRITE_ALLOC = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [AW-1:0]            cpu_addr,
    input  logic [DW-1:0]            cpu_wdata,
    output logic [DW-1:0]            cpu_rdata,
    output logic                     cpu_ready,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [AW-1:0]            bus_addr,
    output logic [DW-1:0]            bus_wdata,
    input  logic                     bus_gnt,
    input  logic                     bus_done,
    input  logic [DW-1:0]            bus_rdata,
    output logic [$clog2(LINES)-1:0] rd_idx,
    input  logic                     rd_vld,
    input  logic [AW-$clog2(LINES)-1:0] rd_tag,
    input  logic [DW-1:0]            rd_data,
    input  logic                     foreign_wr,
    input  logic [AW-1:0]            snp_addr,
    output logic                     fill_en,
    output logic [$clog2(LINES)-1:0] fill_idx,
    output logic [AW-$clog2(LINES)-1:0] fill_tag,
    output logic [DW-1:0]            fill_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = AW - IDX_W;

    wtc_state_e state_q, state_d;
    logic [AW-1:0] r_addr;
    logic          r_we;
    logic [DW-1:0] r_wdata;

    logic [AW-1:0]    cur_addr;
    logic [TAG_W-1:0] cur_tag;
    logic             snp_clash;
    logic             tag_hit;
    logic             accept;

    assign cur_addr  = (state_q == ST_IDLE) ? cpu_addr : r_addr;
    assign cur_tag   = cur_addr[AW-1:IDX_W];
    assign rd_idx    = cur_addr[IDX_W-1:0];
    assign snp_clash = foreign_wr && (snp_addr == cur_addr);
    assign tag_hit   = rd_vld && (rd_tag == cur_tag) && !snp_clash;
    assign accept    = (state_q == ST_IDLE) && cpu_req && (cpu_we || !tag_hit);

    assign bus_addr  = r_addr;
    assign bus_we    = r_we;
    assign bus_wdata = r_wdata;
    assign fill_idx  = r_addr[IDX_W-1:0];
    assign fill_tag  = r_addr[AW-1:IDX_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            r_addr  <= '0;
            r_we    <= 1'b0;
            r_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                r_addr  <= cpu_addr;
                r_we    <= cpu_we;
                r_wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = rd_data;
        bus_req   = 1'b0;
        fill_en   = 1'b0;
        fill_data = bus_rdata;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_we && tag_hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        state_d = ST_BUS_REQ;
                    end
                end
            end
            ST_BUS_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    state_d = ST_BUS_WAIT;
                end
            end
            ST_BUS_WAIT: begin
                cpu_rdata = bus_rdata;
                if (bus_done) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                    if (!r_we) begin
                        fill_en = !snp_clash;
                    end else begin
                        fill_data = r_wdata;
                        fill_en   = !snp_clash && (tag_hit || WRITE_ALLOC);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R11
    no_ready_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    // R4
    wr_via_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> bus_done);

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !bus_done) |-> (!bus_req && !cpu_we));

    // R2
    miss_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we && bus_done) |-> (cpu_rdata == bus_rdata));
endmodule

// File: rtl/wtc_coherence_ctrl.sv
module wtc_coherence_ctrl #(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int LINES       = 8,
    parameter int ID_W        = 2,
    parameter int MY_ID       = 0,
    parameter bit WRITE_ALLOC = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic            cpu_ready,
    output logic            bus_req,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic            bus_gnt,
    input  logic            bus_done,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            snp_valid,
    input  logic            snp_we,
    input  logic [ID_W-1:0] snp_src,
    input  logic [AW-1:0]   snp_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = AW - IDX_W;

    logic [IDX_W-1:0] rd_idx, snp_idx, fill_idx;
    logic             rd_vld, snp_vld, inv_en, foreign_wr, fill_en;
    logic [TAG_W-1:0] rd_tag, snp_tag, fill_tag;
    logic [DW-1:0]    rd_data, fill_data;

    wtc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
        .snp_idx(snp_idx), .snp_vld(snp_vld), .snp_tag(snp_tag),
        .inv_en(inv_en), .inv_idx(snp_idx),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data)
    );

    wtc_snoop #(.AW(AW), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_src(snp_src), .snp_addr(snp_addr),
        .line_vld(snp_vld), .line_tag(snp_tag), .line_idx(snp_idx),
        .inv_en(inv_en), .foreign_wr(foreign_wr)
    );

    wtc_ctrl #(.AW(AW), .DW(DW), .LINES(LINES), .WRITE_ALLOC(WRITE_ALLOC)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
        .foreign_wr(foreign_wr), .snp_addr(snp_addr),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data)
    );
endmodule

// File: tb/sim_wtc_coherence_ctrl.sv
`timescale 1ns/100ps

module sim_bus_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_gnt,
    output logic        bus_done,
    output logic [31:0] bus_rdata,
    input  logic        ext_we,
    input  logic [7:0]  ext_addr,
    input  logic [31:0] ext_data,
    output logic [31:0] tx_cnt,
    output logic [15:0] last_waddr,
    output logic [31:0] last_wdata
);
    logic [31:0] mem [256];
    logic [1:0]  ph;
    logic [7:0]  a_q;
    logic        w_q;
    logic [31:0] d_q;
    logic        cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 + 32'(i) * 32'h0001_0003;
            ph <= 2'd0; bus_gnt <= 1'b0; bus_done <= 1'b0; bus_rdata <= '0;
            a_q <= '0; w_q <= 1'b0; d_q <= '0; cnt <= 1'b0;
            tx_cnt <= '0; last_waddr <= '0; last_wdata <= '0;
        end else begin
            bus_gnt  <= 1'b0;
            bus_done <= 1'b0;
            if (ext_we) mem[ext_addr] <= ext_data;
            case (ph)
                2'd0: if (bus_req) begin
                    bus_gnt <= 1'b1; ph <= 2'd1; cnt <= 1'b1;
                    a_q <= bus_addr[7:0]; w_q <= bus_we; d_q <= bus_wdata;
                    tx_cnt <= tx_cnt + 1;
                end
                2'd1: if (cnt) begin
                    cnt <= 1'b0;
                end else begin
                    bus_done <= 1'b1; bus_rdata <= mem[a_q]; ph <= 2'd2;
                    if (w_q) begin
                        mem[a_q] <= d_q; last_waddr <= {8'h00, a_q}; last_wdata <= d_q;
                    end
                end
                default: ph <= 2'd0;
            endcase
        end
    end
endmodule

module sim_wtc_coherence_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cpu_req [2];
    logic        cpu_we [2];
    logic [15:0] cpu_addr [2];
    logic [31:0] cpu_wdata [2];
    logic [31:0] cpu_rdata [2];
    logic        cpu_ready [2];
    logic        bus_req [2];
    logic        bus_we [2];
    logic [15:0] bus_addr [2];
    logic [31:0] bus_wdata [2];
    logic        bus_gnt [2];
    logic        bus_done [2];
    logic [31:0] bus_rdata [2];
    logic        snp_valid [2];
    logic        snp_we [2];
    logic [1:0]  snp_src [2];
    logic [15:0] snp_addr [2];
    logic        ext_we [2];
    logic [7:0]  ext_addr [2];
    logic [31:0] ext_data [2];
    logic [31:0] tx_cnt [2];
    logic [15:0] last_waddr [2];
    logic [31:0] last_wdata [2];

    wtc_coherence_ctrl #(.WRITE_ALLOC(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]),
        .cpu_rdata(cpu_rdata[0]), .cpu_ready(cpu_ready[0]),
        .bus_req(bus_req[0]), .bus_we(bus_we[0]), .bus_addr(bus_addr[0]), .bus_wdata(bus_wdata[0]),
        .bus_gnt(bus_gnt[0]), .bus_done(bus_done[0]), .bus_rdata(bus_rdata[0]),
        .snp_valid(snp_valid[0]), .snp_we(snp_we[0]), .snp_src(snp_src[0]), .snp_addr(snp_addr[0])
    );

    wtc_coherence_ctrl #(.WRITE_ALLOC(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]),
        .cpu_rdata(cpu_rdata[1]), .cpu_ready(cpu_ready[1]),
        .bus_req(bus_req[1]), .bus_we(bus_we[1]), .bus_addr(bus_addr[1]), .bus_wdata(bus_wdata[1]),
        .bus_gnt(bus_gnt[1]), .bus_done(bus_done[1]), .bus_rdata(bus_rdata[1]),
        .snp_valid(snp_valid[1]), .snp_we(snp_we[1]), .snp_src(snp_src[1]), .snp_addr(snp_addr[1])
    );

    sim_bus_model m0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req[0]), .bus_we(bus_we[0]), .bus_addr(bus_addr[0]),
        .bus_wdata(bus_wdata[0]), .bus_gnt(bus_gnt[0]), .bus_done(bus_done[0]), .bus_rdata(bus_rdata[0]),
        .ext_we(ext_we[0]), .ext_addr(ext_addr[0]), .ext_data(ext_data[0]),
        .tx_cnt(tx_cnt[0]), .last_waddr(last_waddr[0]), .last_wdata(last_wdata[0])
    );

    sim_bus_model m1 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req[1]), .bus_we(bus_we[1]), .bus_addr(bus_addr[1]),
        .bus_wdata(bus_wdata[1]), .bus_gnt(bus_gnt[1]), .bus_done(bus_done[1]), .bus_rdata(bus_rdata[1]),
        .ext_we(ext_we[1]), .ext_addr(ext_addr[1]), .ext_data(ext_data[1]),
        .tx_cnt(tx_cnt[1]), .last_waddr(last_waddr[1]), .last_wdata(last_wdata[1])
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] ref_mem [2][256];
    logic        ref_v [2][8];
    logic [12:0] ref_t [2][8];

    function automatic logic [31:0] init_word(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0003;
    endfunction

    function automatic logic ref_hit(int w, logic [15:0] a);
        return ref_v[w][a[2:0]] && ref_t[w][a[2:0]] == a[15:3];
    endfunction

    function automatic void ref_snoop(int w, logic we, logic foreign, logic [15:0] a, logic [31:0] nd);
        if (we && foreign) begin
            ref_mem[w][a[7:0]] = nd;
            if (ref_hit(w, a)) ref_v[w][a[2:0]] = 1'b0;
        end
    endfunction

    function automatic void ref_access(int w, logic we, logic [15:0] a, logic [31:0] d);
        if (we) begin
            ref_mem[w][a[7:0]] = d;
            if (!ref_hit(w, a) && w == 1) begin
                ref_v[w][a[2:0]] = 1'b1;
                ref_t[w][a[2:0]] = a[15:3];
            end
        end else if (!ref_hit(w, a)) begin
            ref_v[w][a[2:0]] = 1'b1;
            ref_t[w][a[2:0]] = a[15:3];
        end
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive_snoop(input int w, input logic we, input logic [1:0] src,
                               input logic [15:0] a, input logic [31:0] nd);
        snp_valid[w] = 1'b1; snp_we[w] = we; snp_src[w] = src; snp_addr[w] = a;
        if (we && src != 2'd0) begin
            ext_we[w] = 1'b1; ext_addr[w] = a[7:0]; ext_data[w] = nd;
        end
    endtask

    task automatic clear_snoop(input int w);
        snp_valid[w] = 1'b0; snp_we[w] = 1'b0; snp_src[w] = 2'd0; snp_addr[w] = '0;
        ext_we[w] = 1'b0; ext_addr[w] = '0; ext_data[w] = '0;
    endtask

    task automatic snoop_idle(input int w, input logic we, input logic [1:0] src, input logic [15:0] a);
        logic [31:0] nd;
        nd = $urandom;
        @(negedge clk);
        drive_snoop(w, we, src, a, nd);
        ref_snoop(w, we, src != 2'd0, a, nd);
        @(negedge clk);
        clear_snoop(w);
    endtask

    task automatic run_op(input int w, input logic we, input logic [15:0] a, input logic [31:0] d,
                          input bit s_same, input logic [31:0] nd_same,
                          input bit s_done, input logic [31:0] nd_done,
                          output logic [31:0] rd, output bit first_rdy);
        int cyc;
        cyc = 0;
        first_rdy = 1'b0;
        rd = '0;
        @(negedge clk);
        cpu_req[w] = 1'b1; cpu_we[w] = we; cpu_addr[w] = a; cpu_wdata[w] = d;
        if (s_same) drive_snoop(w, 1'b1, 2'd1, a, nd_same);
        forever begin
            #1;
            if (cpu_ready[w]) begin
                rd = cpu_rdata[w];
                first_rdy = (cyc == 0);
                if (s_done) drive_snoop(w, 1'b1, 2'd2, a, nd_done);
                @(posedge clk);
                break;
            end
            @(posedge clk);
            @(negedge clk);
            clear_snoop(w);
            cyc++;
        end
        @(negedge clk);
        cpu_req[w] = 1'b0; cpu_we[w] = 1'b0;
        clear_snoop(w);
    endtask

    task automatic do_op(input int w, input logic we, input logic [15:0] a, input logic [31:0] d,
                         input bit s_same, input bit s_done, input string tag);
        logic [31:0] nd_same, nd_done, exp_data, rd;
        logic [31:0] tx0;
        bit exp_hit, first_rdy, used;
        string rq;
        nd_same = $urandom;
        nd_done = $urandom;
        if (s_same) ref_snoop(w, 1'b1, 1'b1, a, nd_same);
        exp_hit  = !we && ref_hit(w, a);
        exp_data = ref_mem[w][a[7:0]];
        tx0 = tx_cnt[w];
        run_op(w, we, a, d, s_same, nd_same, s_done, nd_done, rd, first_rdy);
        used = (tx_cnt[w] != tx0);
        ref_access(w, we, a, d);
        if (s_done) ref_snoop(w, 1'b1, 1'b1, a, nd_done);
        if (tag != "") rq = tag;
        else if (we) rq = "R4";
        else if (exp_hit) rq = "R3";
        else rq = "R2";
        chk(used == !exp_hit, rq, "bus_used", 32'(used), 32'(!exp_hit));
        if (!we) chk(rd == exp_data, rq, "rdata", rd, exp_data);
        if (we) begin
            chk(last_waddr[w] == a && last_wdata[w] == d, "R4", "bus_write", last_wdata[w], d);
        end
        if (!exp_hit) chk(!first_rdy, "R11", "ready_early", 32'(first_rdy), 32'd0);
        else chk(first_rdy, "R3", "same_cycle_ready", 32'(first_rdy), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int w = 0; w < 2; w++) begin
            clear_snoop(w);
            cpu_req[w] = 1'b0; cpu_we[w] = 1'b0; cpu_addr[w] = '0; cpu_wdata[w] = '0;
            for (int i = 0; i < 256; i++) ref_mem[w][i] = init_word(i);
            for (int i = 0; i < 8; i++) begin ref_v[w][i] = 1'b0; ref_t[w][i] = '0; end
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!cpu_ready[0] && !bus_req[0] && !cpu_ready[1] && !bus_req[1], "R1", "reset_outputs", 32'd0, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int w = 0; w < 2; w++) begin
            do_op(w, 1'b0, 16'h0005, '0, 1'b0, 1'b0, "R1");
            do_op(w, 1'b0, 16'h0005, '0, 1'b0, 1'b0, "R3");
            do_op(w, 1'b1, 16'h0005, 32'hCAFE_0001 + 32'(w), 1'b0, 1'b0, "R4");
            do_op(w, 1'b0, 16'h0005, '0, 1'b0, 1'b0, "R5");
            do_op(w, 1'b1, 16'h0022, 32'h1234_5678, 1'b0, 1'b0, "R4");
            do_op(w, 1'b0, 16'h0022, '0, 1'b0, 1'b0, (w == 0) ? "R6" : "R7");
            snoop_idle(w, 1'b1, 2'd1, 16'h000D);
            do_op(w, 1'b0, 16'h0005, '0, 1'b0, 1'b0, "R8");
            snoop_idle(w, 1'b1, 2'd3, 16'h0005);
            do_op(w, 1'b0, 16'h0005, '0, 1'b0, 1'b0, "R8");
            snoop_idle(w, 1'b0, 2'd1, 16'h0005);
            snoop_idle(w, 1'b1, 2'd0, 16'h0005);
            do_op(w, 1'b0, 16'h0005, '0, 1'b0, 1'b0, "R9");
            do_op(w, 1'b0, 16'h0005, '0, 1'b1, 1'b0, "R10");
            do_op(w, 1'b0, 16'h0030, '0, 1'b0, 1'b1, "R12");
            do_op(w, 1'b0, 16'h0030, '0, 1'b0, 1'b0, "R12");
        end

        for (int n = 0; n < 200; n++) begin
            for (int w = 0; w < 2; w++) begin
                logic [15:0] a;
                int r;
                a = 16'($urandom_range(0, 23));
                r = $urandom_range(0, 9);
                if (r < 2) begin
                    snoop_idle(w, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), a);
                end else begin
                    do_op(w, 1'(r >= 7), a, $urandom, (r == 2), 1'b0, "");
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule